// File: doc/BRIEF.md
# IO Window Access Decoder

This block sits between a CPU data port and the peripheral registers that live in the top 32 KiB of a 24-bit address space. A CPU access of one, two or four bytes arrives as a single-cycle request carrying address, size code, direction, supervisor flag and write data. Every byte address the access covers is sorted into one of four kinds:
- a live register, forwarded to the downstream register port;
- a location that reads 0xFF and drops writes;
- a location that reads 0x00 and drops writes;
- a bus-error location.

A band of addresses repeats the four sound-chip registers through an address mask.

The access as a whole faults only when every byte it covers is a bus-error location, so a word or long that partly overlaps real registers completes, and its error bytes read as 0xFF. Accesses outside the window, accesses made in user mode, and word or long accesses that would run past the top of the address space are handled before any byte is sorted. Two configuration inputs remove optional devices: a disabled blitter turns its registers into bus-error locations, and a disabled clock chip turns its registers into 0xFF locations.

The result comes back one cycle after the request, on `ack`, together with `berr` and the read data. Live bytes are presented to the downstream port during the request cycle, and that port answers in the same cycle.

Top module: `iowin_decoder`

## Requirements
- R1: Only the low 24 bits of `req_addr` take part in decoding. Accesses that differ only in bits 31..24 give identical results.
- R2: Two kinds of access end with `berr`=1, `rdata`=0xFFFFFFFF and no strobes:
  - an access whose 24-bit address is below 0xFF8000;
  - any access made with `req_super`=0.
- R3: Size codes are 0 for byte, 1 for word and 2 for long. Each byte of the access is sorted on its own. `berr` is 1 only when the number of bus-error bytes equals the access size. A partly valid multi-byte access completes with `berr`=0 and strobes only its live bytes.
- R4: In an access that does not fault, each bus-error byte reads 0xFF.
- R5: Offsets 0xFF8000 to 0xFF800F read 0xFF. Offsets 0xFF8900 to 0xFF893F read 0x00. Writes to either range raise no strobe and no bus error.
- R6: Addresses 0xFF8804 to 0xFF88FF are live and reach the downstream port at the address ANDed with 0xFFF803. `dev_lane_addr` carries the 15 low bits of that address.
- R7: A word at 0xFFFFFF, or a long above 0xFFFFFC, is rejected. It gives `berr`=0, `rdata`=0xFFFFFFFF and no strobes. A long at 0xFFFFFC is legal.
- R8: With `cfg_blit_en`=1, addresses 0xFF8A00 to 0xFF8A3F are live. With `cfg_blit_en`=0 they are bus-error locations.
- R9: With `cfg_clock_en`=1, addresses 0xFFFC21 to 0xFFFC3F are live. With `cfg_clock_en`=0 they read 0xFF and ignore writes. Address 0xFFFC20 stays live either way.
- R10: Multi-byte data is big-endian and right-justified:
  - byte k of an N-byte access uses lane N-1-k, and lane j is bits 8j+7..8j;
  - unused lanes read 0x00;
  - `ack` is high for exactly the cycle after each request;
  - `berr` is high only together with `ack`.
- R11: The live ranges are 0xFF8200..0xFF820F, 0xFF8800..0xFF8803, 0xFFFA00..0xFFFA3F and 0xFFFC00..0xFFFC20, together with the ranges in R6, R8 and R9. Any window address not named in a requirement is a bus-error location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address; bits 23..0 decoded |
| req_size | input | 2 | 0 byte, 1 word, 2 long |
| req_write | input | 1 | 1 for write |
| req_super | input | 1 | CPU supervisor flag |
| req_wdata | input | 32 | Right-justified write data |
| cfg_blit_en | input | 1 | Blitter fitted |
| cfg_clock_en | input | 1 | Clock chip fitted |
| ack | output | 1 | Completion, one cycle after request |
| berr | output | 1 | Bus error for the completed access |
| rdata | output | 32 | Read data for the completed access |
| dev_stb | output | 4 | Per-lane strobe to register port |
| dev_we | output | 1 | Write direction for strobed lanes |
| dev_wdata | output | 32 | Lane write data |
| dev_lane_addr | output | 60 | Four 15-bit window offsets, lane j at bits 15j+14..15j |
| dev_rdata | input | 32 | Lane read data from register port, same cycle |

## Verification
On every cycle the assertions check three things:
- the response timing of `ack` and `berr`;
- that a user-mode access always faults and never strobes;
- that no more lanes are strobed than the access covers, and that a rejected end-of-space access never faults.

The byte classes, the mask-based aliasing, the fill values and the lane ordering of read data can only be shown by the bench's scenarios. The bench uses a register model whose data is derived from the lane address. With that model it checks partial faults at region edges, both configuration inputs, and the boundaries at 0xFF8000 and at the top of the space.

// File: rtl/iowin_pkg.sv
`timescale 1ns/1ps
// Shared types and the region map of the IO window decoder.
// Assumes a 32 KiB window whose byte offsets are 15 bits wide.
package iowin_pkg;
    localparam int DEC_W = 24;
    localparam int OFF_W = 15;

    typedef enum logic [1:0] {
        BC_BERR   = 2'd0,
        BC_LIVE   = 2'd1,
        BC_FILL_1 = 2'd2,
        BC_FILL_0 = 2'd3
    } byte_class_e;

    // Window offsets (address minus 0xFF8000), inclusive bounds.
    localparam logic [OFF_W-1:0] ONES_LO  = 15'h0000, ONES_HI  = 15'h000F;
    localparam logic [OFF_W-1:0] VID_LO   = 15'h0200, VID_HI   = 15'h020F;
    localparam logic [OFF_W-1:0] SND_LO   = 15'h0800, SND_HI   = 15'h0803;
    localparam logic [OFF_W-1:0] MIR_LO   = 15'h0804, MIR_HI   = 15'h08FF;
    localparam logic [OFF_W-1:0] ZERO_LO  = 15'h0900, ZERO_HI  = 15'h093F;
    localparam logic [OFF_W-1:0] BLT_LO   = 15'h0A00, BLT_HI   = 15'h0A3F;
    localparam logic [OFF_W-1:0] TMR_LO   = 15'h7A00, TMR_HI   = 15'h7A3F;
    localparam logic [OFF_W-1:0] KBD_LO   = 15'h7C00, KBD_HI   = 15'h7C20;
    localparam logic [OFF_W-1:0] CLK_LO   = 15'h7C21, CLK_HI   = 15'h7C3F;
    localparam logic [OFF_W-1:0] MIR_MASK = 15'h7803;

    function automatic logic in_rng(input logic [OFF_W-1:0] a,
                                    input logic [OFF_W-1:0] lo,
                                    input logic [OFF_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction
endpackage

// File: rtl/iowin_byte_class.sv
`timescale 1ns/1ps
// Sorts one window byte offset into its class and gives the offset the
// register port sees (aliased for the mirror band).
// Assumes the caller has already checked that the address is in the window.
module iowin_byte_class
    import iowin_pkg::*;
#(
    parameter int OW = OFF_W
) (
    input  logic [OW-1:0] off_i,
    input  logic          blit_en_i,
    input  logic          clock_en_i,
    output byte_class_e   cls_o,
    output logic [OW-1:0] dev_off_o
);
    // Region lookup, first match wins; unlisted offsets fault.
    always_comb begin
        dev_off_o = off_i;
        cls_o     = BC_BERR;
        if (in_rng(off_i, ONES_LO, ONES_HI))
            cls_o = BC_FILL_1;
        else if (in_rng(off_i, ZERO_LO, ZERO_HI))
            cls_o = BC_FILL_0;
        else if (in_rng(off_i, VID_LO, VID_HI) || in_rng(off_i, SND_LO, SND_HI)
                 || in_rng(off_i, TMR_LO, TMR_HI) || in_rng(off_i, KBD_LO, KBD_HI))
            cls_o = BC_LIVE;
        else if (in_rng(off_i, MIR_LO, MIR_HI)) begin
            cls_o     = BC_LIVE;
            dev_off_o = off_i & MIR_MASK;
        end
        else if (in_rng(off_i, BLT_LO, BLT_HI))
            cls_o = blit_en_i ? BC_LIVE : BC_BERR;
        else if (in_rng(off_i, CLK_LO, CLK_HI))
            cls_o = clock_en_i ? BC_LIVE : BC_FILL_1;
    end
endmodule

// File: rtl/iowin_decoder.sv
`timescale 1ns/1ps
// IO window access decoder: sorts each byte of a CPU access, decides the
// fault, drives per-lane strobes and returns the response one cycle later.
// Assumes the register port answers dev_rdata in the same cycle as dev_stb.
module iowin_decoder
    import iowin_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_size,
    input  logic                     req_write,
    input  logic                     req_super,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     cfg_blit_en,
    input  logic                     cfg_clock_en,
    output logic                     ack,
    output logic                     berr,
    output logic [DATA_W-1:0]        rdata,
    output logic [DATA_W/8-1:0]      dev_stb,
    output logic                     dev_we,
    output logic [DATA_W-1:0]        dev_wdata,
    output logic [(DATA_W/8)*OFF_W-1:0] dev_lane_addr,
    input  logic [DATA_W-1:0]        dev_rdata
);
    localparam int LANES = DATA_W / 8;
    localparam logic [DEC_W-1:0] WIN_BASE = 24'hFF8000;
    localparam logic [DEC_W-1:0] TOP_WORD = 24'hFFFFFE;
    localparam logic [DEC_W-1:0] TOP_LONG = 24'hFFFFFC;

    logic [DEC_W-1:0] a24;
    logic             unused_hi;
    logic [2:0]       nbytes;
    logic             in_win, illegal, fault, reject;
    logic [2:0]       err_cnt;
    logic [LANES-1:0] live_lane;
    logic [DATA_W-1:0] rd_mix;
    byte_class_e      cls  [LANES];
    logic [OFF_W-1:0] doff [LANES];

    assign a24       = req_addr[DEC_W-1:0];
    assign unused_hi = ^req_addr[ADDR_W-1:DEC_W];
    assign in_win    = (a24 >= WIN_BASE);

    // Byte count of the request from its size code.
    always_comb begin
        case (req_size)
            2'd0:    nbytes = 3'd1;
            2'd1:    nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
    end

    assign illegal = ((nbytes == 3'd2) && (a24 > TOP_WORD)) ||
                     ((nbytes == 3'd4) && (a24 > TOP_LONG));

    // One classifier per byte position of the widest access.
    for (genvar k = 0; k < LANES; k++) begin : g_byte
        iowin_byte_class #(.OW(OFF_W)) u_cls (
            .off_i      (a24[OFF_W-1:0] + OFF_W'(k)),
            .blit_en_i  (cfg_blit_en),
            .clock_en_i (cfg_clock_en),
            .cls_o      (cls[k]),
            .dev_off_o  (doff[k])
        );
    end

    // Map bytes to big-endian right-justified lanes and merge read data.
    always_comb begin
        err_cnt       = '0;
        live_lane     = '0;
        rd_mix        = '0;
        dev_lane_addr = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(nbytes)) begin
                int lane;
                lane = int'(nbytes) - 1 - k;
                dev_lane_addr[OFF_W*lane +: OFF_W] = doff[k];
                case (cls[k])
                    BC_LIVE: begin
                        live_lane[lane]     = 1'b1;
                        rd_mix[8*lane +: 8] = dev_rdata[8*lane +: 8];
                    end
                    BC_FILL_0: rd_mix[8*lane +: 8] = 8'h00;
                    BC_FILL_1: rd_mix[8*lane +: 8] = 8'hFF;
                    default: begin
                        err_cnt             = err_cnt + 3'd1;
                        rd_mix[8*lane +: 8] = 8'hFF;
                    end
                endcase
            end
        end
    end

    assign fault     = !req_super || !in_win || (!illegal && (err_cnt == nbytes));
    assign reject    = !fault && illegal;
    assign dev_stb   = (req_valid && !fault && !reject) ? live_lane : '0;
    assign dev_we    = req_write;
    assign dev_wdata = req_wdata;

    // Response register: completion one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            berr  <= 1'b0;
            rdata <= '0;
        end else begin
            ack  <= req_valid;
            berr <= req_valid && fault;
            if (req_valid)
                rdata <= (fault || reject) ? '1 : rd_mix;
        end
    end

    p_ack_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ack);
    p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !ack);
    p_berr_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> ack);
    p_user_faults_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_super) |=> berr);
    p_user_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_super) |-> (dev_stb == '0));
    p_stb_in_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dev_stb) <= int'(nbytes));
    p_reject_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_super && illegal) |=> !berr);
endmodule

// File: tb/iowin_decoder_test.sv
`timescale 1ns/1ps
module iowin_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_super = 1'b1;
    logic [31:0] req_wdata = '0;
    logic        cfg_blit_en = 1'b1;
    logic        cfg_clock_en = 1'b1;
    logic        ack, berr, dev_we;
    logic [31:0] rdata, dev_wdata, dev_rdata;
    logic [3:0]  dev_stb;
    logic [59:0] dev_lane_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    iowin_decoder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_super(req_super),
        .req_wdata(req_wdata), .cfg_blit_en(cfg_blit_en), .cfg_clock_en(cfg_clock_en),
        .ack(ack), .berr(berr), .rdata(rdata), .dev_stb(dev_stb), .dev_we(dev_we),
        .dev_wdata(dev_wdata), .dev_lane_addr(dev_lane_addr), .dev_rdata(dev_rdata)
    );

    // Register model: each lane returns the low offset byte XOR 0x5A.
    always_comb begin
        for (int j = 0; j < 4; j++)
            dev_rdata[8*j +: 8] = dev_lane_addr[15*j +: 8] ^ 8'h5A;
    end

    typedef struct packed {
        logic        wr;
        logic        sup;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic        e_berr;
        logic [3:0]  e_stb;
        logic [31:0] e_rd;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 2'd0, 32'h00FF8201, 1'b0, 4'b0001, 32'h0000005B}, // R11 live byte
        '{1'b0, 1'b1, 2'd2, 32'h00FF8200, 1'b0, 4'b1111, 32'h5A5B5859}, // R10 long lanes
        '{1'b0, 1'b1, 2'd1, 32'h00FF820F, 1'b0, 4'b0010, 32'h000055FF}, // R3 R4 partial word
        '{1'b0, 1'b1, 2'd0, 32'h00FF8210, 1'b1, 4'b0000, 32'hFFFFFFFF}, // R3 error byte
        '{1'b0, 1'b1, 2'd1, 32'h00FF8500, 1'b1, 4'b0000, 32'hFFFFFFFF}, // R11 unlisted
        '{1'b0, 1'b1, 2'd2, 32'h00FF8000, 1'b0, 4'b0000, 32'hFFFFFFFF}, // R5 ones fill
        '{1'b0, 1'b1, 2'd1, 32'h00FF8900, 1'b0, 4'b0000, 32'h00000000}, // R5 zero fill
        '{1'b1, 1'b1, 2'd0, 32'h00FF8902, 1'b0, 4'b0000, 32'h0},        // R5 write ignored
        '{1'b0, 1'b1, 2'd0, 32'h00FF8805, 1'b0, 4'b0001, 32'h0000005B}, // R6 mirror
        '{1'b0, 1'b1, 2'd1, 32'h00FF88FE, 1'b0, 4'b0011, 32'h00005859}, // R6 mirror word
        '{1'b0, 1'b1, 2'd0, 32'h00FF7FFF, 1'b1, 4'b0000, 32'hFFFFFFFF}, // R2 below window
        '{1'b0, 1'b0, 2'd0, 32'h00FF8201, 1'b1, 4'b0000, 32'hFFFFFFFF}, // R2 user mode
        '{1'b0, 1'b1, 2'd1, 32'h00FFFFFF, 1'b0, 4'b0000, 32'hFFFFFFFF}, // R7 word at top
        '{1'b0, 1'b1, 2'd2, 32'h00FFFFFD, 1'b0, 4'b0000, 32'hFFFFFFFF}, // R7 long past top
        '{1'b0, 1'b1, 2'd2, 32'h00FFFFFC, 1'b1, 4'b0000, 32'hFFFFFFFF}, // R7 legal long
        '{1'b0, 1'b1, 2'd0, 32'hABFF8201, 1'b0, 4'b0001, 32'h0000005B}, // R1 upper bits
        '{1'b0, 1'b1, 2'd2, 32'h00FFFA3E, 1'b0, 4'b1100, 32'h6465FFFF}, // R4 long edge
        '{1'b1, 1'b1, 2'd0, 32'h00FF8203, 1'b0, 4'b0001, 32'h0},        // R10 byte write
        '{1'b1, 1'b1, 2'd2, 32'h00FF820E, 1'b0, 4'b1100, 32'h0},        // R3 partial write
        '{1'b1, 1'b0, 2'd1, 32'h00FF8200, 1'b1, 4'b0000, 32'h0}         // R2 user write
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    logic [3:0]  s_stb;
    logic [59:0] s_la;
    logic        s_berr, s_ack;
    logic [31:0] s_rd;

    // One request cycle; strobes sampled mid-cycle, response one cycle on.
    task automatic access(input logic wr, input logic sup, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_super = sup;
        req_size = sz; req_addr = a; req_wdata = wd;
        #1;
        s_stb = dev_stb; s_la = dev_lane_addr;
        @(negedge clk);
        req_valid = 1'b0;
        s_berr = berr; s_rd = rdata; s_ack = ack;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ack == 1'b0 && berr == 1'b0, "R10 reset ack/berr", {30'b0, ack, berr}, 32'h0);
        chk(rdata == 32'h0, "R10 reset rdata", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack == 1'b0, "R10 idle ack", {31'b0, ack}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].sup, VEC[i].sz, VEC[i].addr, 32'hC3A5_1E77);
            chk(s_ack == 1'b1, $sformatf("R10 ack vec %0d", i), {31'b0, s_ack}, 32'h1);
            chk(s_berr == VEC[i].e_berr, $sformatf("R3 berr vec %0d", i),
                {31'b0, s_berr}, {31'b0, VEC[i].e_berr});
            chk(s_stb == VEC[i].e_stb, $sformatf("R3 stb vec %0d", i),
                {28'b0, s_stb}, {28'b0, VEC[i].e_stb});
            if (!VEC[i].wr)
                chk(s_rd == VEC[i].e_rd, $sformatf("R4 rdata vec %0d", i), s_rd, VEC[i].e_rd);
        end
        @(negedge clk);
        chk(ack == 1'b0, "R10 ack single cycle", {31'b0, ack}, 32'h0);

        // R6: mirrored write reaches the aliased offset with the write data.
        access(1'b1, 1'b1, 2'd0, 32'h00FF8806, 32'h0000_0042);
        chk(s_la[14:0] == 15'h0802, "R6 alias lane addr", {17'b0, s_la[14:0]}, 32'h0802);
        chk(s_stb == 4'b0001, "R6 alias strobe", {28'b0, s_stb}, 32'h1);

        // R8: blitter registers follow cfg_blit_en.
        access(1'b0, 1'b1, 2'd0, 32'h00FF8A10, 32'h0);
        chk(!s_berr && s_rd == 32'h4A, "R8 blit on", s_rd, 32'h4A);
        cfg_blit_en = 1'b0;
        access(1'b0, 1'b1, 2'd0, 32'h00FF8A10, 32'h0);
        chk(s_berr == 1'b1 && s_stb == 4'b0, "R8 blit off", {31'b0, s_berr}, 32'h1);
        cfg_blit_en = 1'b1;

        // R9: clock chip registers follow cfg_clock_en, 0xFFFC20 unaffected.
        access(1'b0, 1'b1, 2'd0, 32'h00FFFC21, 32'h0);
        chk(!s_berr && s_rd == 32'h7B, "R9 clock on", s_rd, 32'h7B);
        cfg_clock_en = 1'b0;
        access(1'b0, 1'b1, 2'd0, 32'h00FFFC21, 32'h0);
        chk(!s_berr && s_rd == 32'hFF && s_stb == 4'b0, "R9 clock off read", s_rd, 32'hFF);
        access(1'b1, 1'b1, 2'd0, 32'h00FFFC30, 32'h55);
        chk(!s_berr && s_stb == 4'b0, "R9 clock off write", {28'b0, s_stb}, 32'h0);
        access(1'b0, 1'b1, 2'd0, 32'h00FFFC20, 32'h0);
        chk(!s_berr && s_rd == 32'h7A, "R9 0xFFFC20 live", s_rd, 32'h7A);
        cfg_clock_en = 1'b1;

        // R1: bits above 23 do not move an out-of-window address into the window.
        access(1'b0, 1'b1, 2'd0, 32'hFF7F8201, 32'h0);
        chk(s_berr == 1'b1, "R1 high bits ignored", {31'b0, s_berr}, 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule